// File: doc/BRIEF.md
# Range-Filter Scan with Dense Compaction

This block filters a column of keys against a closed window. On every accepted beat it takes a vector of key lanes, each paired with a row offset. It compares all lanes at once against a lower and an upper bound held on configuration inputs, which gives one pass bit per lane. The offsets of the lanes that pass are then packed to the front of an output vector.

Survivors keep their lane order. Output slots past the last survivor read as zero. A running write index moves forward by the number of survivors, so consecutive beats describe one dense list of matching row offsets. A downstream writer can store each beat at the reported base index without branching per row.

Both sides use valid/ready handshakes. One output register decouples the sides, and the input is refused while that register holds a result the consumer has not taken.

Top module: `range_compact_scan`

## Requirements
- R1: A lane passes exactly when `lo_bound <= key` and `key <= hi_bound`, comparing unsigned, with both ends inclusive. Lane i of `in_keys` is bits [i*32 +: 32], and lane i of `in_offs` is bits [i*32 +: 32].
- R2: `out_mask` bit i is 1 when lane i of the accepted beat passed and 0 otherwise.
- R3: The offsets of the passing lanes appear in ascending lane order in output slots 0, 1, 2 and so on. Slot j of `out_offs` is bits [j*32 +: 32].
- R4: Every output slot at or above `out_count` reads zero.
- R5: `out_count` equals the number of set bits in `out_mask`. `out_valid` is raised for every accepted beat, including one with no survivors.
- R6: `out_base` gives the write index at the start of the beat. The index grows by `out_count` after each beat and wraps modulo 2^16.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and every output holds steady. No beat is lost or repeated, including a beat accepted in the same cycle as the previous result drains.
- R8: A synchronous high `rst` clears `out_valid` and resets the write index, so the first beat after reset reports `out_base` 0.
- R9: With `lo_bound` greater than `hi_bound`, no lane passes and the beat still produces a valid result with count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lo_bound | input | 32 | Inclusive lower bound of the window |
| hi_bound | input | 32 | Inclusive upper bound of the window |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat |
| in_keys | input | 256 | Eight 32-bit keys, lane 0 in the low bits |
| in_offs | input | 256 | Eight 32-bit row offsets, lane 0 in the low bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_mask | output | 8 | Pass bit per lane |
| out_offs | output | 256 | Compacted offsets, slot 0 in the low bits |
| out_count | output | 4 | Number of passing lanes |
| out_base | output | 16 | Write index at which this beat's survivors start |

## Verification
The bench targets keys that sit exactly on either bound, a window of width zero, an inverted window, and beats where every lane or no lane survives.

A design with a strict compare drops boundary lanes. A design with a faulty prefix sum puts survivors in the wrong slot or leaves stale data above the count. A design that withholds valid on an empty beat stalls the stream.

The bench also holds the consumer off while a new beat waits, then releases it. A design that ignores back-pressure overwrites the held result, and one with a broken index update reports a wrong base for the beat that drains and loads in the same cycle.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  localparam int MAX_LANES = 64;

  // number of set bits among the lowest n bits of m
  function automatic logic [6:0] ones_below(input logic [MAX_LANES-1:0] m, input int n);
    logic [6:0] acc;
    acc = '0;
    for (int b = 0; b < MAX_LANES; b++) begin
      if (b < n && m[b]) acc = acc + 7'd1;
    end
    return acc;
  endfunction

endpackage

// File: rtl/rcs_lane_cmp.sv
module rcs_lane_cmp #(
  parameter int LANES = 8,
  parameter int KEY_W = 32
) (
  input  logic [LANES*KEY_W-1:0] keys,
  input  logic [KEY_W-1:0]       lo,
  input  logic [KEY_W-1:0]       hi,
  output logic [LANES-1:0]       hit
);

  function automatic logic in_window(input logic [KEY_W-1:0] k,
                                     input logic [KEY_W-1:0] l,
                                     input logic [KEY_W-1:0] h);
    return (k >= l) && (k <= h);
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign hit[g] = in_window(keys[g*KEY_W +: KEY_W], lo, hi);
  end

endmodule

// File: rtl/rcs_packer.sv
module rcs_packer
  import rcs_pkg::*;
#(
  parameter int LANES = 8,
  parameter int OFF_W = 32,
  parameter int CNT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES-1:0]       hit,
  input  logic [LANES*OFF_W-1:0] offs,
  output logic [LANES*OFF_W-1:0] packed_offs,
  output logic [CNT_W-1:0]       cnt
);

  localparam int SLOT_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [MAX_LANES-1:0] hit_wide;
  logic [SLOT_W-1:0]    dest [LANES];

  assign hit_wide = MAX_LANES'(hit);

  // exclusive prefix sum: destination slot of each lane
  for (genvar g = 0; g < LANES; g++) begin : g_dest
    assign dest[g] = SLOT_W'(ones_below(hit_wide, g));
  end

  assign cnt = CNT_W'(ones_below(hit_wide, LANES));

  always_comb begin
    packed_offs = '0;
    for (int i = 0; i < LANES; i++) begin
      if (hit[i]) packed_offs[dest[i]*OFF_W +: OFF_W] = offs[i*OFF_W +: OFF_W];
    end
  end

  // R5
  count_matches_mask_chk: assert property (@(posedge clk) disable iff (rst)
    32'(cnt) == $countones(hit));

  for (genvar j = 0; j < LANES; j++) begin : g_zero_chk
    // R4
    tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (32'(j) >= 32'(cnt)) |-> (packed_offs[j*OFF_W +: OFF_W] == '0));
  end

endmodule

// File: rtl/rcs_out_stage.sv
module rcs_out_stage #(
  parameter int LANES = 8,
  parameter int OFF_W = 32,
  parameter int CNT_W = 4,
  parameter int IDX_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES-1:0]       hit,
  input  logic [LANES*OFF_W-1:0] packed_offs,
  input  logic [CNT_W-1:0]       cnt,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES-1:0]       out_mask,
  output logic [LANES*OFF_W-1:0] out_offs,
  output logic [CNT_W-1:0]       out_count,
  output logic [IDX_W-1:0]       out_base
);

  logic [IDX_W-1:0] wr_idx;
  logic             take;
  logic             drain;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign drain    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_idx    <= '0;
      out_mask  <= '0;
      out_offs  <= '0;
      out_count <= '0;
      out_base  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_mask  <= hit;
      out_offs  <= packed_offs;
      out_count <= cnt;
      out_base  <= wr_idx;
      wr_idx    <= wr_idx + IDX_W'(cnt);
    end else if (drain) begin
      out_valid <= 1'b0;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_offs) &&
                                   $stable(out_count) && $stable(out_base)));

  // R7
  accept_shows_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R6
  base_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && in_valid && in_ready) |=>
      (out_base == $past(out_base) + IDX_W'($past(out_count))));

endmodule

// File: rtl/range_compact_scan.sv
module range_compact_scan #(
  parameter int LANES = 8,
  parameter int KEY_W = 32,
  parameter int OFF_W = 32,
  parameter int IDX_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [KEY_W-1:0]       lo_bound,
  input  logic [KEY_W-1:0]       hi_bound,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*KEY_W-1:0] in_keys,
  input  logic [LANES*OFF_W-1:0] in_offs,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES-1:0]       out_mask,
  output logic [LANES*OFF_W-1:0] out_offs,
  output logic [$clog2(LANES+1)-1:0] out_count,
  output logic [IDX_W-1:0]       out_base
);

  localparam int CNT_W = $clog2(LANES + 1);

  logic [LANES-1:0]       lane_hit;
  logic [LANES*OFF_W-1:0] dense_offs;
  logic [CNT_W-1:0]       hit_cnt;

  rcs_lane_cmp #(.LANES(LANES), .KEY_W(KEY_W)) u_cmp (
    .keys (in_keys),
    .lo   (lo_bound),
    .hi   (hi_bound),
    .hit  (lane_hit)
  );

  rcs_packer #(.LANES(LANES), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_pack (
    .clk         (clk),
    .rst         (rst),
    .hit         (lane_hit),
    .offs        (in_offs),
    .packed_offs (dense_offs),
    .cnt         (hit_cnt)
  );

  rcs_out_stage #(.LANES(LANES), .OFF_W(OFF_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .hit         (lane_hit),
    .packed_offs (dense_offs),
    .cnt         (hit_cnt),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_mask    (out_mask),
    .out_offs    (out_offs),
    .out_count   (out_count),
    .out_base    (out_base)
  );

endmodule

// File: tb/range_compact_scan_tb.sv
`timescale 1ns/1ps
module range_compact_scan_tb;

  localparam int NT = 7;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [31:0]  lo_bound = '0, hi_bound = '0;
  logic         in_valid = 1'b0, out_ready = 1'b1;
  logic [255:0] in_keys = '0, in_offs = '0;
  logic         in_ready, out_valid;
  logic [7:0]   out_mask;
  logic [255:0] out_offs;
  logic [3:0]   out_count;
  logic [15:0]  out_base;

  int total = 0;
  int bad   = 0;
  logic [15:0] exp_base = '0;

  always #2.5 clk = ~clk;

  range_compact_scan u_dut (
    .clk(clk), .rst(rst), .lo_bound(lo_bound), .hi_bound(hi_bound),
    .in_valid(in_valid), .in_ready(in_ready), .in_keys(in_keys), .in_offs(in_offs),
    .out_valid(out_valid), .out_ready(out_ready), .out_mask(out_mask),
    .out_offs(out_offs), .out_count(out_count), .out_base(out_base)
  );

  localparam logic [31:0] T_LO [NT] = '{32'h4F, 32'h0, 32'd100, 32'd10, 32'd50, 32'd7, 32'd1000};
  localparam logic [31:0] T_HI [NT] = '{32'h55, 32'hFFFF_FFFF, 32'd200, 32'd20, 32'd40, 32'd7, 32'd2000};
  localparam logic [255:0] T_KEYS [NT] = '{
    {32'h50, 32'h41, 32'h58, 32'h55, 32'h53, 32'h59, 32'h4F, 32'h4A},
    {32'hFFFF_FFFF, 32'd0, 32'd9, 32'd8, 32'd7, 32'd6, 32'd5, 32'd4},
    {32'd7, 32'd6, 32'd5, 32'd4, 32'd3, 32'd2, 32'd1, 32'd0},
    {32'hFFFF_FFFF, 32'd0, 32'd15, 32'd21, 32'd20, 32'd11, 32'd10, 32'd9},
    {32'd45, 32'd40, 32'd50, 32'd45, 32'd41, 32'd49, 32'd50, 32'd40},
    {32'd7, 32'd0, 32'd7, 32'd7, 32'd8, 32'd7, 32'd6, 32'd7},
    {32'd1500, 32'd6, 32'd5, 32'd4, 32'd3, 32'd2, 32'd1, 32'd0}};
  // expected pass mask, bit i = lane i
  localparam logic [7:0] T_MASK [NT] = '{8'h9A, 8'hFF, 8'h00, 8'h2E, 8'h00, 8'hB5, 8'h80};
  localparam string T_TAG [NT] = '{"R1", "R1", "R1", "R1", "R9", "R1", "R1"};

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // checks the offsets vector against mask and lane offsets, own packing
  task automatic chk_pack(input logic [7:0] m, input logic [255:0] offs);
    logic [31:0] want [8];
    int k;
    k = 0;
    for (int s = 0; s < 8; s++) want[s] = '0;
    for (int i = 0; i < 8; i++) begin
      if (m[i]) begin
        want[k] = offs[i*32 +: 32];
        k++;
      end
    end
    for (int s = 0; s < 8; s++) begin
      if (s < k) chk(out_offs[s*32 +: 32] == want[s], "R3 packed slot", out_offs[s*32 +: 32], want[s]);
      else       chk(out_offs[s*32 +: 32] == 32'd0, "R4 zero slot", out_offs[s*32 +: 32], 0);
    end
    chk(out_count == 4'(k), "R5 count", out_count, k);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [255:0] offs_v;
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    chk(out_valid == 1'b0, "R8 valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R8 ready after reset", in_ready, 1);
    chk(out_count == 4'd0, "R8 count after reset", out_count, 0);
    @(negedge clk); rst = 1'b0;

    // table walk
    for (int t = 0; t < NT; t++) begin
      @(negedge clk);
      for (int i = 0; i < 8; i++) offs_v[i*32 +: 32] = 32'(t*100 + i);
      lo_bound = T_LO[t]; hi_bound = T_HI[t];
      in_keys = T_KEYS[t]; in_offs = offs_v; in_valid = 1'b1; out_ready = 1'b1;
      tick();
      chk(out_valid == 1'b1, "R5 valid per beat", out_valid, 1);
      chk(out_mask == T_MASK[t], {T_TAG[t], " R2 mask"}, out_mask, T_MASK[t]);
      chk(out_base == exp_base, "R6 base", out_base, exp_base);
      chk_pack(T_MASK[t], offs_v);
      exp_base = exp_base + 16'($countones(T_MASK[t]));
      @(negedge clk); in_valid = 1'b0;
    end
    tick();
    chk(out_valid == 1'b0, "R7 valid drops after drain", out_valid, 0);

    // back-pressure: beat A (all pass) held, beat B (none pass) waits
    @(negedge clk);
    lo_bound = 32'd10; hi_bound = 32'd20; out_ready = 1'b0; in_valid = 1'b1;
    for (int i = 0; i < 8; i++) begin
      in_keys[i*32 +: 32] = 32'd15;
      in_offs[i*32 +: 32] = 32'(500 + i);
    end
    tick();
    chk(out_valid == 1'b1, "R7 A shown", out_valid, 1);
    chk(in_ready == 1'b0, "R7 ready low on stall", in_ready, 0);
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      in_keys[i*32 +: 32] = 32'd0;
      in_offs[i*32 +: 32] = 32'(900 + i);
    end
    for (int c = 0; c < 3; c++) begin
      tick();
      chk(out_count == 4'd8, "R7 held count", out_count, 8);
      chk(out_offs[31:0] == 32'd500, "R7 held slot0", out_offs[31:0], 500);
      chk(out_base == exp_base, "R7 held base", out_base, exp_base);
    end
    @(negedge clk); out_ready = 1'b1;
    tick();
    exp_base = exp_base + 16'd8;
    chk(out_valid == 1'b1, "R5 valid with zero survivors", out_valid, 1);
    chk(out_count == 4'd0, "R5 zero count", out_count, 0);
    chk(out_base == exp_base, "R6 base after drain-and-load", out_base, exp_base);
    chk(out_offs == '0, "R4 all slots zero", out_offs[63:0], 0);
    @(negedge clk); in_valid = 1'b0;
    tick();
    chk(out_valid == 1'b0, "R7 no duplicate beat", out_valid, 0);

    // reset mid-stream
    @(negedge clk); rst = 1'b1;
    tick();
    chk(out_valid == 1'b0, "R8 valid cleared", out_valid, 0);
    @(negedge clk); rst = 1'b0; in_valid = 1'b1;
    for (int i = 0; i < 8; i++) in_keys[i*32 +: 32] = 32'd15;
    tick();
    chk(out_base == 16'd0, "R8 index restarts", out_base, 0);
    @(negedge clk); in_valid = 1'b0;
    tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule